// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block counts enabled processor clock cycles and produces the timing pulses that drive the slow parts of a sound unit. It issues single-cycle quarter-frame and half-frame strobes that go to the envelope, linear-counter, length-counter and sweep logic. In one of its two sequence modes it also raises a frame interrupt. The interrupt is held in a flag, and the flag drives an active-low IRQ line.

Software has two registers. The first is a write-only control byte: bit 7 picks the sequence mode and bit 6 inhibits the interrupt. The second is a status byte that shows the flag in bit 6, and a read of it clears the flag. A write to the control byte restarts the count from zero. A soft reset applies the last control value written again. A power-up reset acts as if zero had been written.

The step points are parameters. Their defaults are 7456, 14912, 22370, 29828 and 37280 cycles. Cycle k after a restart is the k-th enabled cycle after the restarting edge, and the first such cycle is cycle 0.

Top module: `frame_seq`

## Requirements
- R1: Counting from a restart, qtr_stb pulses alone at cycles STEP1 and STEP3, and qtr_stb and half_stb pulse together at STEP2. half_stb never pulses without qtr_stb.
- R2: In 4-step mode (control bit 7 = 0), qtr_stb and half_stb pulse together at STEP4. The count returns to 0 after cycle STEP4+2, so the sequence repeats every STEP4+3 cycles.
- R3: In 4-step mode with the inhibit clear, the flag is set during cycles STEP4, STEP4+1 and STEP4+2, and irq_n falls in the cycle after STEP4. A status read in one of those cycles does not clear the flag.
- R4: In 5-step mode (control bit 7 = 1), no strobe occurs at STEP4, both strobes pulse at STEP5, and the count repeats every STEP5+1 cycles. The flag is never set in this mode.
- R5: A control write with bit 6 = 1 sets the inhibit and clears the flag, so irq_n is high in the next cycle. A control write with bit 6 = 0 clears the inhibit and leaves the flag unchanged.
- R6: A control write with bit 7 = 1 produces one qtr_stb and one half_stb together in the cycle that follows the write.
- R7: stat_rdata carries the flag in bit 6 and zero in all other bits. A stat_rd pulse clears the flag from the next cycle, and irq_n then rises, unless a set happens in the same cycle.
- R8: During and after a power-up reset (rst), the block behaves as if 0x00 had been written: irq_n is high, stat_rdata is zero, 4-step mode is selected with interrupts enabled, and the count starts at 0 in the first cycle after rst falls.
- R9: soft_rst applies the last written control value again. It restarts the count, reloads the mode and inhibit, and applies the bit 6 flag rule. If that value has bit 7 set, it also produces the immediate strobes.
- R10: The count advances, and sequence strobes and flag sets happen, only in cycles where cpu_en is high. Register writes, soft resets and status reads act whatever cpu_en is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cpu_en | input | 1 | Processor-cycle enable for the counter |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 mode, bit 6 interrupt inhibit |
| soft_rst | input | 1 | Apply the last written control byte again |
| stat_rd | input | 1 | Status read strobe, clears the flag |
| stat_rdata | output | 8 | Status byte, flag in bit 6 |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the sequencer with step points of 10, 20, 30, 40 and 50 cycles in place of the tens of thousands in the defaults. With these values several full frames of both modes fit in a short run, including the wrap back to zero and the three-cycle flag window. They also leave room for status reads placed inside that window and just after it, for control writes and soft resets while the flag is set, and for a stretch with the enable held low, all checked cycle by cycle against a queue of expected strobes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int CTL_W    = 8;
    localparam int MODE_BIT = 7;
    localparam int INH_BIT  = 6;
    localparam int FLAG_BIT = 6;
    localparam int NPTS     = 5;

    // per step point: which ones emit a quarter / half strobe in each mode
    localparam logic [NPTS-1:0] QTR_MASK_4 = 5'b01111;
    localparam logic [NPTS-1:0] QTR_MASK_5 = 5'b10111;
    localparam logic [NPTS-1:0] HALF_MASK_4 = 5'b01010;
    localparam logic [NPTS-1:0] HALF_MASK_5 = 5'b10010;

    typedef enum logic {
        SEQ_4STEP = 1'b0,
        SEQ_5STEP = 1'b1
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e mode;
        logic      inhibit;
    } ctl_s;

    typedef struct packed {
        logic qtr;
        logic half;
    } stb_s;

    function automatic ctl_s decode_ctl(input logic [CTL_W-1:0] v);
        ctl_s c;
        c.mode    = seq_mode_e'(v[MODE_BIT]);
        c.inhibit = v[INH_BIT];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] pack_status(input logic flag);
        logic [CTL_W-1:0] s;
        s = '0;
        s[FLAG_BIT] = flag;
        return s;
    endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             soft_rst,
    output ctl_s             ctl,
    output logic             restart,
    output logic             clr_flag,
    output logic             imm_stb
);

    logic [CTL_W-1:0] last_q;
    ctl_s             ctl_q;
    logic             imm_q;
    logic [CTL_W-1:0] apply_val;
    ctl_s             apply_ctl;

    always_comb begin
        restart   = ctl_wr | soft_rst;
        apply_val = ctl_wr ? ctl_wdata : last_q;
        apply_ctl = decode_ctl(apply_val);
        clr_flag  = restart & apply_ctl.inhibit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            ctl_q  <= decode_ctl('0);
            imm_q  <= 1'b0;
        end else begin
            imm_q <= restart && (apply_ctl.mode == SEQ_5STEP);
            if (restart) ctl_q <= apply_ctl;
            if (ctl_wr)  last_q <= ctl_wdata;
        end
    end

    assign ctl     = ctl_q;
    assign imm_stb = imm_q;

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import fseq_pkg::*;
#(
    parameter int STEP1 = 7456,
    parameter int STEP2 = 14912,
    parameter int STEP3 = 22370,
    parameter int STEP4 = 29828,
    parameter int STEP5 = 37280
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cen,
    input  logic      restart,
    input  seq_mode_e mode,
    output stb_s      stb,
    output logic      irq_win
);

    localparam int LAST4 = STEP4 + 2;
    localparam int LAST  = (STEP5 > LAST4) ? STEP5 : LAST4;
    localparam int CW    = $clog2(LAST + 1);

    localparam logic [CW-1:0] PTS [NPTS] = '{CW'(STEP1), CW'(STEP2), CW'(STEP3),
                                             CW'(STEP4), CW'(STEP5)};

    logic [CW-1:0]   cnt_q;
    logic [NPTS-1:0] hit;
    logic [CW-1:0]   wrap_pt;
    logic            at_end;
    logic            m5;

    for (genvar i = 0; i < NPTS; i++) begin : g_hit
        assign hit[i] = (cnt_q == PTS[i]);
    end

    always_comb begin
        m5       = (mode == SEQ_5STEP);
        wrap_pt  = m5 ? CW'(STEP5) : CW'(LAST4);
        at_end   = (cnt_q == wrap_pt);
        stb.qtr  = cen && |(hit & (m5 ? QTR_MASK_5 : QTR_MASK_4));
        stb.half = cen && |(hit & (m5 ? HALF_MASK_5 : HALF_MASK_4));
        irq_win  = cen && !m5 && (cnt_q >= CW'(STEP4)) && (cnt_q <= CW'(LAST4));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cen) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr_wr,
    input  logic rd,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (clr_wr) flag_q <= 1'b0;
        else if (set)    flag_q <= 1'b1;
        else if (rd)     flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import fseq_pkg::*;
#(
    parameter int STEP1 = 7456,
    parameter int STEP2 = 14912,
    parameter int STEP3 = 22370,
    parameter int STEP4 = 29828,
    parameter int STEP5 = 37280
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_en,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic       soft_rst,
    input  logic       stat_rd,
    output logic [7:0] stat_rdata,
    output logic       qtr_stb,
    output logic       half_stb,
    output logic       irq_n
);

    ctl_s ctl_st;
    logic restart;
    logic clr_flag;
    logic imm_stb;
    stb_s seq_stb;
    logic irq_win;
    logic flag;

    fseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .soft_rst  (soft_rst),
        .ctl       (ctl_st),
        .restart   (restart),
        .clr_flag  (clr_flag),
        .imm_stb   (imm_stb)
    );

    fseq_timer #(
        .STEP1 (STEP1),
        .STEP2 (STEP2),
        .STEP3 (STEP3),
        .STEP4 (STEP4),
        .STEP5 (STEP5)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cen     (cpu_en),
        .restart (restart),
        .mode    (ctl_st.mode),
        .stb     (seq_stb),
        .irq_win (irq_win)
    );

    fseq_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (irq_win && !ctl_st.inhibit),
        .clr_wr (clr_flag),
        .rd     (stat_rd),
        .flag   (flag)
    );

    assign qtr_stb    = seq_stb.qtr  | imm_stb;
    assign half_stb   = seq_stb.half | imm_stb;
    assign irq_n      = ~flag;
    assign stat_rdata = pack_status(flag);

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic clk,
    input logic rst,
    input logic cpu_en,
    input logic ctl_wr,
    input logic wr_inh,
    input logic wr_mode,
    input logic soft_rst,
    input logic stat_rd,
    input logic qtr_stb,
    input logic half_stb,
    input logic irq_n,
    input logic mode5
);

    // R1
    half_needs_qtr_chk: assert property (@(posedge clk) disable iff (rst)
        half_stb |-> qtr_stb);

    // R4
    no_irq_in_5step_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && $past(irq_n)) |-> !$past(mode5));

    // R5
    inhibit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_inh) |=> irq_n);

    // R6
    imm_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wr_mode) |=> (qtr_stb && half_stb));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !cpu_en) |=> irq_n);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_n && !half_stb));

    // R10
    stall_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_en && $past(!ctl_wr && !soft_rst)) |-> !qtr_stb);

endmodule

bind frame_seq fseq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_en   (cpu_en),
    .ctl_wr   (ctl_wr),
    .wr_inh   (ctl_wdata[6]),
    .wr_mode  (ctl_wdata[7]),
    .soft_rst (soft_rst),
    .stat_rd  (stat_rd),
    .qtr_stb  (qtr_stb),
    .half_stb (half_stb),
    .irq_n    (irq_n),
    .mode5    (ctl_st.mode)
);

// File: tb/sim_frame_seq.sv
`timescale 1ns/1ps
module sim_frame_seq;

    localparam int S1 = 10, S2 = 20, S3 = 30, S4 = 40, S5 = 50;
    localparam int P4 = S4 + 3;
    localparam int P5 = S5 + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_en = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       soft_rst = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       qtr_stb, half_stb, irq_n;

    frame_seq #(.STEP1(S1), .STEP2(S2), .STEP3(S3), .STEP4(S4), .STEP5(S5)) u0 (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .soft_rst(soft_rst), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .qtr_stb(qtr_stb), .half_stb(half_stb), .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    q;
        bit    h;
        string req;
    } ev_t;

    ev_t sbq[$];
    int  horizon = -1;
    int  vec = 0;
    int  bad = 0;
    bit  done = 0;

    task automatic chk(string req, string what, int act, int exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    task automatic push(int at, bit q, bit h, string req);
        ev_t e;
        e.at = at; e.q = q; e.h = h; e.req = req;
        sbq.push_back(e);
        horizon = at;
    endtask

    // cnt == k during cycle base+k; two frames are queued to cover the wrap
    task automatic push_frame(int base, bit m5, bit imm, string req);
        if (imm) push(base, 1, 1, "R6");
        for (int f = 0; f < 2; f++) begin
            int o;
            o = base + f * (m5 ? P5 : P4);
            push(o + S1, 1, 0, "R1");
            push(o + S2, 1, 1, "R1");
            push(o + S3, 1, 0, "R1");
            if (m5) push(o + S5, 1, 1, req);
            else    push(o + S4, 1, 1, req);
        end
    endtask

    task automatic wait_to(int x);
        while (cyc < x) @(negedge clk);
    endtask

    task automatic do_write(logic [7:0] v, output int b);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        b = cyc + 1;
        sbq.delete();
        horizon = -1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_soft(output int b);
        soft_rst = 1'b1;
        b = cyc + 1;
        sbq.delete();
        horizon = -1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    // monitor: pops expected strobe items and compares them
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() > 0 && sbq[0].at == cyc) begin
                ev_t e;
                e = sbq.pop_front();
                chk(e.req, "strobe pair {qtr,half}", int'({qtr_stb, half_stb}), int'({e.q, e.h}));
            end else if (!done && cyc <= horizon && (qtr_stb || half_stb)) begin
                chk("R1", "unexpected strobe {qtr,half}", int'({qtr_stb, half_stb}), 0);
            end
        end
    end

    initial begin
        #(20000 * 8);
        bad++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int b, c;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8", "irq_n in reset", irq_n, 1);
        chk("R8", "stat_rdata in reset", stat_rdata, 0);
        chk("R8", "strobes in reset", int'({qtr_stb, half_stb}), 0);

        // R8 power-up acts as a zero write: 4-step with interrupts
        rst = 1'b0;
        b = cyc;
        push_frame(b, 0, 0, "R2");
        wait_to(b + S4);
        chk("R3", "irq_n in first set cycle", irq_n, 1);
        wait_to(b + S4 + 1);
        chk("R8", "irq enabled after power-up", irq_n, 0);
        chk("R7", "status flag bit 6", stat_rdata, 8'h40);
        stat_rd = 1'b1;
        wait_to(b + S4 + 2);
        chk("R3", "read during set window loses", irq_n, 0);
        wait_to(b + S4 + 3);
        chk("R3", "read in last set cycle loses", irq_n, 0);
        wait_to(b + S4 + 4);
        stat_rd = 1'b0;
        chk("R7", "read after window clears", irq_n, 1);
        chk("R7", "status after clear", stat_rdata, 0);
        wait_to(b + P4 + S4 + 2);
        chk("R2", "flag set again after wrap", irq_n, 0);

        // R5 bit 6 clear keeps the flag
        do_write(8'h00, b);
        push_frame(b, 0, 0, "R2");
        chk("R5", "write bit6=0 keeps flag", irq_n, 0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R7", "read clears flag", irq_n, 1);
        wait_to(b + S4 + 1);
        chk("R3", "flag set after restart", irq_n, 0);

        // R5 bit 6 set clears and inhibits
        do_write(8'h40, b);
        push_frame(b, 0, 0, "R2");
        chk("R5", "write bit6=1 clears flag", irq_n, 1);
        wait_to(b + S4 + 3);
        chk("R5", "inhibit holds irq off", irq_n, 1);
        wait_to(b + P4 + S4 + 3);
        chk("R5", "inhibit holds irq off frame 2", irq_n, 1);

        // R4 5-step mode with immediate strobes
        do_write(8'h80, b);
        push_frame(b, 1, 1, "R4");
        wait_to(b + S4 + 3);
        chk("R4", "no irq in 5-step at step4", irq_n, 1);
        wait_to(b + P5 + S5 + 1);
        chk("R4", "no irq after 5-step frames", irq_n, 1);

        // R9 soft reset applies last value (5-step)
        do_soft(b);
        push_frame(b, 1, 1, "R9");
        wait_to(b + P5 + S5 + 1);
        chk("R9", "soft reset kept 5-step, no irq", irq_n, 1);

        // R9 soft reset with last value zero keeps the flag
        do_write(8'h00, b);
        push_frame(b, 0, 0, "R2");
        wait_to(b + S4 + 3);
        chk("R3", "flag set in 4-step", irq_n, 0);
        do_soft(b);
        push_frame(b, 0, 0, "R9");
        chk("R9", "soft reset bit6=0 keeps flag", irq_n, 0);
        wait_to(b + 2);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R7", "read outside window clears", irq_n, 1);
        wait_to(b + S4 + 1);
        chk("R9", "4-step irq after soft reset", irq_n, 0);
        stat_rd = 1'b1;
        wait_to(b + S4 + 4);
        stat_rd = 1'b0;

        // R10 enable low stalls the count
        ctl_wr = 1'b1;
        ctl_wdata = 8'h00;
        cpu_en = 1'b0;
        sbq.delete();
        horizon = -1;
        c = cyc;
        @(negedge clk);
        ctl_wr = 1'b0;
        wait_to(c + 6);
        cpu_en = 1'b1;
        push_frame(c + 6, 0, 0, "R10");
        wait_to(c + 6 + S4);
        chk("R10", "irq not yet set after stall", irq_n, 1);
        wait_to(c + 6 + S4 + 1);
        chk("R10", "irq set shifted by stall", irq_n, 0);
        wait_to(horizon + 2);
        chk("R1", "all queued strobes seen", sbq.size(), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule